// File: doc/BRIEF.md
# Block Address Translation Array

This block maps 32-bit effective addresses to 32-bit physical addresses for large, naturally aligned regions. Each region is a power of two in size, from 128 KB up to 256 MB. It sits next to a page TLB. It keeps a small, fully associative table of region descriptors and compares every lookup against all of them in the same cycle. On a match it returns the translated address, the index of the matching descriptor and a protection verdict. The verdict depends on the privilege level (supervisor or user) and on the access kind (load or store).

The block also makes the final choice between its own result and a TLB result, which comes in on a separate port. A region match always takes precedence over a TLB hit. Descriptors are loaded through a single-cycle write port. Results are registered, so they appear one cycle after the request.

Top module: `bat_xlate`

## Requirements
- R1: After reset every descriptor is invalid, and every output is 0. A lookup made before any write reports no region hit.
- R2: `rsp_valid_o` equals `req_valid_i` from the previous cycle. While `rsp_valid_o` is 0, the outputs `hit_o`, `bat_hit_o`, `bat_idx_o`, `fault_o` and `pa_o` are all 0.
- R3: A descriptor matches when both of the following hold. First, EA[31:28] equals its effective index bits [14:11]. Second, EA[27:17] equals its effective index bits [10:0] in every bit position where its size mask is 0. Mask bit i governs EA bit 17+i. A mask of 0 gives a 128 KB region, and a mask of all ones gives a 256 MB region.
- R4: A supervisor lookup (`sup_i`=1) can only match a descriptor whose supervisor-valid bit is set. A user lookup can only match a descriptor whose user-valid bit is set.
- R5: On a region hit, the physical address is built in three parts. PA[31:28] is the physical index bits [14:11]. PA[16:0] is EA[16:0]. Each bit PA[17+i] is EA[17+i] where mask bit i is 1, and physical index bit i where mask bit i is 0.
- R6: When several descriptors match, the one with the lowest index supplies the result.
- R7: A region hit overrides a TLB hit in the same request. When there is no region hit, `hit_o` follows `tlb_hit_i` and `pa_o` is `tlb_pa_i` (or 0 if there is no TLB hit). `bat_hit_o` stays 0 in that case.
- R8: The protection field is 2 bits: 00 is no access, 01 and 11 are read-only, and 10 is read/write. `fault_o` is set on a region hit when the field is 00, or when a store (`store_i`=1) meets 01 or 11. A faulting hit still reports its hit and its address. A TLB-only result never sets `fault_o`.
- R9: A descriptor written in one cycle affects lookups from the next cycle on. A lookup made in the same cycle as the write sees the old contents.
- R10: `bat_idx_o` gives the index of the winning descriptor on a region hit, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load a descriptor |
| wr_idx_i | input | 2 | Descriptor slot to load |
| wr_bepi_i | input | 15 | Effective index of the region (EA[31:17]) |
| wr_mask_i | input | 11 | Size mask over EA[27:17] |
| wr_sv_i | input | 1 | Valid for supervisor lookups |
| wr_uv_i | input | 1 | Valid for user lookups |
| wr_brpn_i | input | 15 | Physical index of the region (PA[31:17]) |
| wr_pp_i | input | 2 | Protection field |
| req_valid_i | input | 1 | Lookup request |
| ea_i | input | 32 | Effective address |
| sup_i | input | 1 | 1 = supervisor access |
| store_i | input | 1 | 1 = store, 0 = load |
| tlb_hit_i | input | 1 | TLB hit for this request |
| tlb_pa_i | input | 32 | TLB physical address |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Region or TLB translation found |
| bat_hit_o | output | 1 | Result came from the region table |
| bat_idx_o | output | 2 | Winning descriptor index |
| pa_o | output | 32 | Selected physical address |
| fault_o | output | 1 | Protection violation on a region hit |

## Verification
Every result of a request is due on the first rising edge after the request is presented. The bench drives inputs on the falling edge and reads all outputs on the next falling edge, one edge after sampling. It computes its expectation when it drives the request, from its own descriptor table as it stands before any write in that cycle. It applies the write to that table only after the edge. This reproduces the rule that a write becomes visible one cycle later, without relying on process order at the edge.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned BLK_W  = 15;
  localparam int unsigned MASK_W = 11;
  localparam int unsigned OFF_W  = ADDR_W - BLK_W;
  localparam int unsigned FIX_W  = BLK_W - MASK_W;

  typedef struct packed {
    logic [BLK_W-1:0]  bepi;
    logic [MASK_W-1:0] mask;
    logic              sv;
    logic              uv;
    logic [BLK_W-1:0]  brpn;
    logic [1:0]        pp;
  } bat_entry_t;

  // 00 none, 01/11 read-only, 10 read/write
  function automatic logic prot_fault(input logic [1:0] pp, input logic store);
    return (pp == 2'b00) || (store && pp[0]);
  endfunction
endpackage

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
(
  input  logic [BLK_W-1:0]  bepi_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              sv_i,
  input  logic              uv_i,
  input  logic [BLK_W-1:0]  brpn_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              sup_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] pa_o
);
  logic [MASK_W-1:0] ea_mid;
  logic [MASK_W-1:0] diff;
  logic              fix_eq;
  logic              priv_ok;

  assign ea_mid  = ea_i[OFF_W +: MASK_W];
  assign diff    = (ea_mid ^ bepi_i[MASK_W-1:0]) & ~mask_i;
  assign fix_eq  = ea_i[ADDR_W-1 -: FIX_W] == bepi_i[BLK_W-1 -: FIX_W];
  assign priv_ok = sup_i ? sv_i : uv_i;
  assign hit_o   = fix_eq && (diff == '0) && priv_ok;
  assign pa_o    = {brpn_i[BLK_W-1 -: FIX_W],
                    (brpn_i[MASK_W-1:0] & ~mask_i) | (ea_mid & mask_i),
                    ea_i[OFF_W-1:0]};
endmodule

// File: rtl/bat_prio.sv
module bat_prio
  import bat_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
)(
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][ADDR_W-1:0] pa_i,
  input  logic [N-1:0][1:0]        pp_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [ADDR_W-1:0]        pa_o,
  output logic [1:0]               pp_o
);
  // scan downward so the lowest index is assigned last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    pa_o  = '0;
    pp_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        pa_o  = pa_i[i];
        pp_o  = pp_i[i];
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BLK_W-1:0]  wr_bepi_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic              wr_sv_i,
  input  logic              wr_uv_i,
  input  logic [BLK_W-1:0]  wr_brpn_i,
  input  logic [1:0]        wr_pp_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              sup_i,
  input  logic              store_i,
  input  logic              tlb_hit_i,
  input  logic [ADDR_W-1:0] tlb_pa_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              bat_hit_o,
  output logic [IDX_W-1:0]  bat_idx_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic              fault_o
);
  bat_entry_t                   tbl_q [NUM_ENT];
  bat_entry_t                   wr_ent;
  logic [NUM_ENT-1:0]           ent_hit;
  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_pa;
  logic [NUM_ENT-1:0][1:0]      ent_pp;
  logic                         bat_any;
  logic [IDX_W-1:0]             bat_idx;
  logic [ADDR_W-1:0]            bat_pa;
  logic [1:0]                   bat_pp;

  assign wr_ent = '{bepi: wr_bepi_i, mask: wr_mask_i, sv: wr_sv_i, uv: wr_uv_i,
                    brpn: wr_brpn_i, pp: wr_pp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENT; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_ENT; i++)
        if (wr_idx_i == IDX_W'(i)) tbl_q[i] <= wr_ent;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    bat_match u_match (
      .bepi_i (tbl_q[g].bepi),
      .mask_i (tbl_q[g].mask),
      .sv_i   (tbl_q[g].sv),
      .uv_i   (tbl_q[g].uv),
      .brpn_i (tbl_q[g].brpn),
      .ea_i   (ea_i),
      .sup_i  (sup_i),
      .hit_o  (ent_hit[g]),
      .pa_o   (ent_pa[g])
    );
    assign ent_pp[g] = tbl_q[g].pp;
  end

  bat_prio #(.N(NUM_ENT), .IDX_W(IDX_W)) u_prio (
    .hit_i (ent_hit),
    .pa_i  (ent_pa),
    .pp_i  (ent_pp),
    .any_o (bat_any),
    .idx_o (bat_idx),
    .pa_o  (bat_pa),
    .pp_o  (bat_pp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      bat_hit_o   <= 1'b0;
      bat_idx_o   <= '0;
      pa_o        <= '0;
      fault_o     <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      hit_o       <= req_valid_i && (bat_any || tlb_hit_i);
      bat_hit_o   <= req_valid_i && bat_any;
      bat_idx_o   <= (req_valid_i && bat_any) ? bat_idx : '0;
      fault_o     <= req_valid_i && bat_any && prot_fault(bat_pp, store_i);
      if (!req_valid_i)   pa_o <= '0;
      else if (bat_any)   pa_o <= bat_pa;
      else if (tlb_hit_i) pa_o <= tlb_pa_i;
      else                pa_o <= '0;
    end
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
)(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [OFF_W-1:0]  ea_lo_i,
  input logic              tlb_hit_i,
  input logic [ADDR_W-1:0] tlb_pa_i,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic              bat_hit_o,
  input logic [IDX_W-1:0]  bat_idx_o,
  input logic [ADDR_W-1:0] pa_o,
  input logic              fault_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!hit_o && !bat_hit_o && !fault_o && pa_o == '0)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!bat_hit_o || pa_o[OFF_W-1:0] == $past(ea_lo_i))); // R5
  AST_TLB_HIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tlb_hit_i) |=> hit_o); // R7
  AST_TLB_PA_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tlb_hit_i) |=> (bat_hit_o || pa_o == $past(tlb_pa_i))); // R7
  AST_BAT_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_hit_o |-> hit_o); // R7
  AST_FAULT_ON_BAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> bat_hit_o); // R8
  AST_IDX_ZERO_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_hit_o |-> bat_idx_o == '0); // R10
endmodule

bind bat_xlate bat_xlate_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ea_lo_i     (ea_i[bat_pkg::OFF_W-1:0]),
  .tlb_hit_i   (tlb_hit_i),
  .tlb_pa_i    (tlb_pa_i),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .bat_hit_o   (bat_hit_o),
  .bat_idx_o   (bat_idx_o),
  .pa_o        (pa_o),
  .fault_o     (fault_o)
);

// File: tb/sim_bat_xlate.sv
module sim_bat_xlate;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NE = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [14:0] wr_bepi_i = '0;
  logic [10:0] wr_mask_i = '0;
  logic        wr_sv_i = 1'b0;
  logic        wr_uv_i = 1'b0;
  logic [14:0] wr_brpn_i = '0;
  logic [1:0]  wr_pp_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic        sup_i = 1'b0;
  logic        store_i = 1'b0;
  logic        tlb_hit_i = 1'b0;
  logic [31:0] tlb_pa_i = '0;
  logic        rsp_valid_o, hit_o, bat_hit_o, fault_o;
  logic [1:0]  bat_idx_o;
  logic [31:0] pa_o;

  int checks = 0;
  int errors = 0;

  // reference table
  logic [14:0] m_bepi [NE];
  logic [10:0] m_mask [NE];
  logic        m_sv [NE];
  logic        m_uv [NE];
  logic [14:0] m_brpn [NE];
  logic [1:0]  m_pp [NE];

  logic [37:0] exp_vec = '0;
  string       exp_tag = "R1";

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bat_xlate u0 (.*);

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [37:0] model(input logic rv, input logic [31:0] ea,
                                        input logic sup, input logic st,
                                        input logic th, input logic [31:0] tpa);
    for (int e = 0; e < NE; e++) begin
      logic ok;
      logic [31:0] pa;
      logic flt;
      ok = sup ? m_sv[e] : m_uv[e];
      for (int b = 17; b < 32; b++)
        if (!(b < 28 && m_mask[e][b-17]) && ea[b] != m_bepi[e][b-17]) ok = 1'b0;
      if (rv && ok) begin
        for (int b = 0; b < 32; b++)
          pa[b] = (b < 17) ? ea[b] : (b < 28 && m_mask[e][b-17]) ? ea[b] : m_brpn[e][b-17];
        flt = (m_pp[e] == 2'b00) || (st && (m_pp[e] != 2'b10));
        return {1'b1, 1'b1, 1'b1, 2'(e), pa, flt};
      end
    end
    if (!rv) return '0;
    return {1'b1, th, 1'b0, 2'b00, th ? tpa : 32'h0, 1'b0};
  endfunction

  task automatic compare();
    logic [37:0] act;
    act = {rsp_valid_o, hit_o, bat_hit_o, bat_idx_o, pa_o, fault_o};
    checks++;
    if (act !== exp_vec) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", exp_tag, act, exp_vec);
    end
  endtask

  task automatic set_wr(input int idx, input logic [14:0] bepi, input logic [10:0] mask,
                        input logic sv, input logic uv, input logic [14:0] brpn,
                        input logic [1:0] pp);
    wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_bepi_i = bepi; wr_mask_i = mask;
    wr_sv_i = sv; wr_uv_i = uv; wr_brpn_i = brpn; wr_pp_i = pp;
  endtask

  // one cycle: check the previous result, drive a new request, commit model write after edge
  task automatic step(input logic rv, input logic [31:0] ea, input logic sup, input logic st,
                      input logic th, input logic [31:0] tpa, input string tag);
    compare();
    req_valid_i = rv; ea_i = ea; sup_i = sup; store_i = st; tlb_hit_i = th; tlb_pa_i = tpa;
    exp_vec = model(rv, ea, sup, st, th, tpa);
    exp_tag = tag;
    @(posedge clk_i);
    if (wr_en_i) begin
      m_bepi[wr_idx_i] = wr_bepi_i; m_mask[wr_idx_i] = wr_mask_i;
      m_sv[wr_idx_i] = wr_sv_i; m_uv[wr_idx_i] = wr_uv_i;
      m_brpn[wr_idx_i] = wr_brpn_i; m_pp[wr_idx_i] = wr_pp_i;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_bepi[e] = '0; m_mask[e] = '0; m_sv[e] = 0; m_uv[e] = 0; m_brpn[e] = '0; m_pp[e] = '0;
    end
    #(CLK_PERIOD * 3);
    exp_vec = '0; exp_tag = "R1 reset";
    compare();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_tag = "R1 idle";

    step(1, 32'h0020_1234, 1, 0, 0, 0, "R1 empty table");
    step(0, 32'h0020_1234, 1, 0, 0, 0, "R2 idle");
    set_wr(0, 15'h0010, 11'h000, 1, 0, 15'h0100, 2'b10);
    step(1, 32'h0020_1234, 1, 0, 0, 0, "R9 same-cycle write");
    step(1, 32'h0020_1234, 1, 0, 0, 0, "R3 R5 128KB hit");
    step(1, 32'h0021_FFFF, 1, 1, 0, 0, "R3 top of block");
    step(1, 32'h0022_0000, 1, 0, 0, 0, "R3 past block");
    step(1, 32'h0020_1234, 0, 0, 1, 32'hDEAD_B000, "R4 R7 user falls to TLB");
    set_wr(1, 15'h0800, 11'h7FF, 1, 1, 15'h0400, 2'b01);
    step(0, 0, 0, 0, 0, 0, "R2 write cycle");
    step(1, 32'h1ABC_DEF0, 0, 0, 0, 0, "R3 R5 256MB load");
    step(1, 32'h1ABC_DEF0, 0, 1, 0, 0, "R8 store read-only");
    set_wr(2, 15'h0010, 11'h00F, 1, 0, 15'h0200, 2'b10);
    step(0, 0, 0, 0, 0, 0, "R2 write cycle");
    step(1, 32'h0020_1234, 1, 1, 0, 0, "R6 lowest wins");
    step(1, 32'h0030_0040, 1, 1, 0, 0, "R6 R10 entry two");
    step(1, 32'h0020_1234, 1, 0, 1, 32'h1111_2000, "R7 region beats TLB");
    set_wr(3, 15'h0100, 11'h000, 1, 0, 15'h7FFF, 2'b00);
    step(1, 32'h0200_0000, 1, 0, 1, 32'h0000_4000, "R9 old contents");
    step(1, 32'h0200_0000, 1, 0, 0, 0, "R8 R10 no-access load");
    set_wr(0, 15'h0010, 11'h000, 0, 0, 15'h0100, 2'b10);
    step(0, 0, 0, 0, 0, 0, "R2 write cycle");
    step(1, 32'h0020_1234, 1, 0, 0, 0, "R4 R6 invalidated entry");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ea;
      logic [10:0] mk;
      if ($urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 3))
          0: mk = 11'h000;
          1: mk = 11'h7FF;
          2: mk = 11'h00F;
          default: mk = 11'($urandom);
        endcase
        set_wr(int'($urandom_range(0, 3)), {4'h1, 7'h0, 4'($urandom)}, mk,
               1'($urandom), 1'($urandom), 15'($urandom), 2'($urandom));
      end
      ea = {4'h1, 7'h0, 4'($urandom), 17'($urandom)};
      if ($urandom_range(0, 3) == 0) ea = $urandom;
      step(1'($urandom_range(0, 7) != 0), ea, 1'($urandom), 1'($urandom),
           1'($urandom), $urandom, "R3 R6 R8 random");
    end
    compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule